// File: doc/BRIEF.md
# Byte-Serial Checksum Accumulator

This block folds a stream of bytes into a 32-bit remainder, one byte per clock, using the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009). Bytes enter most-significant bit first. The register is neither reflected on input nor on output, and no final XOR is applied. The value on the result port is the raw remainder, and it can be read in any cycle.

To begin a message, software or a sequencer pulses a start strobe together with a seed value, normally all ones. Each accepted byte is XORed into the top eight bits of the remainder. The remainder is then advanced through eight shift steps. In each step the polynomial is XORed in whenever the bit shifted out is set. The whole eight-step update is combinational, so the input is ready in every cycle outside reset. A start and a byte presented in the same cycle fold that byte into the fresh seed.

Top module: `crc_byte_engine`

## Requirements
- R1: While synchronous reset is high, the remainder is cleared to 0x00000000, and it reads zero in the cycle after reset is sampled.
- R2: A start pulse with no valid byte makes the output equal to the seed input one clock later.
- R3: A valid byte without start updates the remainder one clock later. The update XORs the byte into bits 31:24 and then runs eight left shifts, each XORing 0x20044009 when the bit shifted out of bit 31 was 1.
- R4: Starting from seed 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 on consecutive clocks yield 0xF33CB7D3.
- R5: When start and a valid byte arrive in the same cycle, the byte is folded into the seed rather than into the old remainder.
- R6: In a cycle with neither start nor a valid byte, the output keeps its value.
- R7: Ready is high in every cycle in which reset is low. As a result, bytes presented on back-to-back clocks are all accepted.
- R8: No final inversion or reflection is applied. From a zero remainder, the single byte 0x01 yields exactly 0x20044009, and the byte 0x00 leaves the remainder at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Loads seedIn as the new remainder |
| seedIn | input | 32 | Initial remainder for a new message |
| byteValid | input | 1 | byteData carries a byte to fold |
| byteData | input | 8 | Input byte, MSB processed first |
| byteReady | output | 1 | Byte accepted when high with byteValid |
| crcOut | output | 32 | Current remainder |

## Verification
The hardest case to reach from the ports is a start and a byte in the same cycle. In that case the byte must be folded into the seed, not into the stale remainder. The stimulus leaves a non-trivial remainder from an earlier message in the register and then raises both strobes in one cycle with a different seed, so that folding against the wrong base produces a visibly different value. The stimulus also checks the eight-step chain at the bit level: a single 0x01 byte into a zero register must surface the polynomial exactly.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef struct packed {
    logic clear;
    logic loadSeed;
    logic foldByte;
  } crc_ctrl_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
(
  input  logic      rst,
  input  logic      startIn,
  input  logic      byteValid,
  output logic      byteReady,
  output crc_ctrl_t strobes
);
  always_comb begin
    byteReady        = ~rst;
    strobes.clear    = rst;
    strobes.loadSeed = startIn & ~rst;
    strobes.foldByte = byteValid & ~rst;
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int          WIDTH  = 32,
  parameter int          BYTE_W = 8,
  parameter logic [31:0] POLY   = 32'h2004_4009
) (
  input  logic              clk,
  input  crc_ctrl_t         strobes,
  input  logic [WIDTH-1:0]  seedIn,
  input  logic [BYTE_W-1:0] byteData,
  output logic [WIDTH-1:0]  crcOut
);
  localparam int PAD = WIDTH - BYTE_W;
  localparam logic [WIDTH-1:0] POLY_W = POLY[WIDTH-1:0];

  logic [WIDTH-1:0] crcReg;
  logic [WIDTH-1:0] baseVal;
  logic [WIDTH-1:0] stage [0:BYTE_W];

  always_comb begin
    baseVal  = strobes.loadSeed ? seedIn : crcReg;
    stage[0] = baseVal ^ {byteData, {PAD{1'b0}}};
  end

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bitStep
    always_comb begin
      if (stage[k][WIDTH-1]) stage[k+1] = {stage[k][WIDTH-2:0], 1'b0} ^ POLY_W;
      else                   stage[k+1] = {stage[k][WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)         crcReg <= '0;
    else if (strobes.foldByte) crcReg <= stage[BYTE_W];
    else if (strobes.loadSeed) crcReg <= seedIn;
  end

  assign crcOut = crcReg;
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startIn,
  input  logic [31:0] seedIn,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        byteReady,
  output logic [31:0] crcOut
);
  crc_ctrl_t strobes;

  crc_ctrl u_ctrl (
    .rst       (rst),
    .startIn   (startIn),
    .byteValid (byteValid),
    .byteReady (byteReady),
    .strobes   (strobes)
  );

  crc_datapath #(.WIDTH(32), .BYTE_W(8), .POLY(32'h2004_4009)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .seedIn   (seedIn),
    .byteData (byteData),
    .crcOut   (crcOut)
  );
endmodule

// File: rtl/crc_checker.sv
module crc_checker (
  input logic        clk,
  input logic        rst,
  input logic        startIn,
  input logic [31:0] seedIn,
  input logic        byteValid,
  input logic        byteReady,
  input logic [31:0] crcOut
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> crcOut == 32'h0);

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
    (startIn && !byteValid) |=> crcOut == $past(seedIn));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!startIn && !byteValid) |=> $stable(crcOut));

  assert_ready_after_reset_R7: assert property (@(posedge clk)
    $fell(rst) |-> byteReady);
endmodule

bind crc_byte_engine crc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .startIn   (startIn),
  .seedIn    (seedIn),
  .byteValid (byteValid),
  .byteReady (byteReady),
  .crcOut    (crcOut)
);

// File: tb/sim_crc_byte_engine.sv
module sim_crc_byte_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        startIn;
  logic [31:0] seedIn;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        byteReady;
  logic [31:0] crcOut;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  crc_byte_engine u0 (
    .clk(clk), .rst(rst), .startIn(startIn), .seedIn(seedIn),
    .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .crcOut(crcOut)
  );

  // {start, valid, byte, seed}
  localparam int NVEC = 10;
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 8'hA5, 32'h0},
    {1'b0, 1'b1, 8'h3C, 32'h0},
    {1'b0, 1'b0, 8'hEE, 32'h1234_5678},
    {1'b0, 1'b1, 8'h00, 32'h0},
    {1'b0, 1'b1, 8'hFF, 32'h0},
    {1'b1, 1'b1, 8'h5A, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 8'h80, 32'h0},
    {1'b1, 1'b0, 8'h77, 32'h0000_0000},
    {1'b0, 1'b1, 8'h01, 32'h0}
  };

  function automatic logic [31:0] fold(input logic [31:0] r, input logic [7:0] b);
    logic [31:0] c;
    c = r ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) begin
      if (c[31]) c = (c << 1) ^ 32'h2004_4009;
      else       c = c << 1;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic [7:0] b, input logic [31:0] sd);
    startIn = s; byteValid = v; byteData = b; seedIn = sd;
    @(posedge clk);
    @(negedge clk);
    if (v) model = fold(s ? sd : model, b);
    else if (s) model = sd;
    startIn = 1'b0; byteValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; startIn = 1'b0; byteValid = 1'b0; byteData = 8'h0; seedIn = 32'h0;
    model = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset clears", crcOut, 32'h0);
    check("R7 ready low in reset", {31'h0, byteReady}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 ready after reset", {31'h0, byteReady}, 32'h1);

    // table walk covers R2, R3, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][41], VEC[i][40], VEC[i][39:32], VEC[i][31:0]);
      check("R2/R3/R5/R6 table", crcOut, model);
    end

    // R4 known vector, back-to-back bytes (R7)
    drive(1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF);
    check("R2 seed load", crcOut, 32'hFFFF_FFFF);
    startIn = 1'b0; byteValid = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      byteData = 8'(i);
      check("R7 ready during burst", {31'h0, byteReady}, 32'h1);
      @(posedge clk);
      @(negedge clk);
    end
    byteValid = 1'b0;
    check("R4 known vector", crcOut, 32'hF33C_B7D3);

    // R6 hold over idle cycles
    repeat (5) @(negedge clk);
    check("R6 idle hold", crcOut, 32'hF33C_B7D3);

    // R5: start+valid folds into seed, not stale remainder
    drive(1'b1, 1'b1, 8'h01, 32'h0000_0000);
    check("R5 fold into new seed", crcOut, 32'h2004_4009);
    check("R8 single 0x01 gives polynomial", crcOut, 32'h2004_4009);

    // R8 zero byte on zero register
    drive(1'b1, 1'b1, 8'h00, 32'h0000_0000);
    check("R8 zero stays zero", crcOut, 32'h0);

    // R3 single byte from seed
    drive(1'b1, 1'b0, 8'h00, 32'hCAFE_F00D);
    drive(1'b0, 1'b1, 8'h96, 32'h0);
    check("R3 single fold", crcOut, fold(32'hCAFE_F00D, 8'h96));

    // R1 mid-stream reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-stream reset", crcOut, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule